// File: doc/BRIEF.md
# Programmable LCD Raster Timing Generator

This block drives the timing side of a parallel TFT panel: horizontal sync, vertical sync, data enable, the pixel column and row inside the visible area, a line-paced bias toggle and a pulse that counts those toggles. It runs on the pixel clock. Software programs it through a simple write-only register port. The port holds one raster control word and three timing words, and several fields in the timing words are split into a low part and a high part.

Timing words are staged when they are written. The running configuration is reloaded from them only at the first pixel of a new frame, or on every clock while the raster is disabled. A frame that is already being scanned therefore keeps one consistent geometry. Each line runs sync, back porch, active area, front porch. Each frame follows the same order in lines.

Top module: `lcdt_raster`

## Requirements
- R1: While reset is held, and on the first clock after it, every output is 0: sync, enable, position, bias, pulse and the static flags.
- R2: Horizontal decoding. The active width is ({t0[3], t0[9:4]} + 1) × 16 pixels. The sync width is {t2[30:27], t0[15:10]} + 1. The front porch is {t2[1:0], t0[23:16]} + 1. The back porch is {t2[5:4], t0[31:24]} + 1. One line lasts the sum of these four values in clocks.
- R3: Vertical decoding. The active height is {t2[26], t1[9:0]} + 1 lines. The sync height is t1[15:10] + 1. The front porch is t1[23:16] lines and the back porch is t1[31:24] lines, both taken as raw counts that may be zero.
- R4: A line runs sync, back porch, active, front porch, and a frame runs the same order in lines. Horizontal sync is active during the first sync-width pixels of every line. Vertical sync is active during the first sync-height lines. The first clock edge after enabling outputs column 0 of line 0, and the outputs follow the counters one clock later.
- R5: Data enable is active only when both counters are inside their active ranges. While it is active, pixel_x and pixel_y give the offset from the first active column and row. Otherwise both read 0.
- R6: Bits t2[20], t2[21] and t2[23] invert vertical sync, horizontal sync and data enable. Bit t2[22] is presented on pclk_invert.
- R7: sync_fall_edge is 1 only when both t2[25] (edge selection on) and t2[24] (falling edge) are set.
- R8: The register addresses are 0 for raster control, 1 for t0, 2 for t1 and 3 for t2. Control bit 0 enables the raster and bit 7 is presented on tft_mode. On the clock after enable is seen cleared, the counters are at zero and every output shows its inactive level.
- R9: A timing write made while the raster runs takes effect only from the first pixel of the next frame. While the raster is disabled, a write takes effect on the following clock.
- R10: The bias output toggles at the end of every N-th line, where N = t2[15:8]. N = 0 holds it steady. Disabling the raster returns it to 0.
- R11: ac_irq pulses for one clock on every M-th bias toggle, where M = t2[19:16]. M = 0 gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 t0, 2 t1, 3 t2 |
| reg_wdata | input | 32 | Register write data |
| lcd_hsync | output | 1 | Horizontal sync, polarity applied |
| lcd_vsync | output | 1 | Vertical sync, polarity applied |
| lcd_de | output | 1 | Data enable, polarity applied |
| pixel_x | output | 13 | Active column, 0 outside the active area |
| pixel_y | output | 12 | Active row, 0 outside the active area |
| ac_bias | output | 1 | Line-paced bias toggle |
| ac_irq | output | 1 | One-clock pulse every M bias toggles |
| pclk_invert | output | 1 | Pixel clock inversion request |
| sync_fall_edge | output | 1 | Sync launched on the falling pixel clock edge |
| tft_mode | output | 1 | TFT panel mode flag |

## Verification
If the horizontal counter goes wrong, the bad value reaches the sync or enable pins within one clock, because every output is a registered decode of the counters. A vertical counter or a shadow configuration that reloads at the wrong moment shows at the ports only at the next line or frame boundary: sync, enable or bias then starts on the wrong clock. The bench's model compares every output on every clock, so both kinds of fault are caught at their first visible clock.

// File: rtl/lcdt_pkg.sv
// Package for the raster timing generator.
// Holds the counter widths, the register addresses and the decoded
// configuration record, plus the function that unpacks the register words.
// Assumes the register layout given in the brief.
package lcdt_pkg;

    localparam int HCNT_W = 13;   // holds sync+porches+2048 active pixels
    localparam int VCNT_W = 12;   // holds 2048 lines plus vertical blanking
    localparam int REG_W  = 32;
    localparam int ADDR_W = 2;
    localparam int ACN_W  = 8;
    localparam int ACM_W  = 4;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_T0   = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_T1   = 2'd2;
    localparam logic [ADDR_W-1:0] ADDR_T2   = 2'd3;

    typedef struct packed {
        logic [HCNT_W-1:0] h_sync;
        logic [HCNT_W-1:0] h_back;
        logic [HCNT_W-1:0] h_act;
        logic [HCNT_W-1:0] h_front;
        logic [VCNT_W-1:0] v_sync;
        logic [VCNT_W-1:0] v_back;
        logic [VCNT_W-1:0] v_act;
        logic [VCNT_W-1:0] v_front;
        logic [ACN_W-1:0]  ac_lines;
        logic [ACM_W-1:0]  ac_irq_every;
        logic              inv_vs;
        logic              inv_hs;
        logic              inv_pclk;
        logic              inv_de;
        logic              sync_fall;
        logic              tft;
    } lcdt_cfg_t;

    // Turn the packed, partly minus-one coded register words into plain counts.
    function automatic lcdt_cfg_t lcdt_decode(input logic [REG_W-1:0] ctrl,
                                              input logic [REG_W-1:0] t0,
                                              input logic [REG_W-1:0] t1,
                                              input logic [REG_W-1:0] t2);
        lcdt_cfg_t c;
        c.h_act        = (HCNT_W'({t0[3], t0[9:4]}) + HCNT_W'(1)) << 4;
        c.h_sync       = HCNT_W'({t2[30:27], t0[15:10]}) + HCNT_W'(1);
        c.h_front      = HCNT_W'({t2[1:0], t0[23:16]}) + HCNT_W'(1);
        c.h_back       = HCNT_W'({t2[5:4], t0[31:24]}) + HCNT_W'(1);
        c.v_act        = VCNT_W'({t2[26], t1[9:0]}) + VCNT_W'(1);
        c.v_sync       = VCNT_W'(t1[15:10]) + VCNT_W'(1);
        c.v_front      = VCNT_W'(t1[23:16]);
        c.v_back       = VCNT_W'(t1[31:24]);
        c.ac_lines     = t2[15:8];
        c.ac_irq_every = t2[19:16];
        c.inv_vs       = t2[20];
        c.inv_hs       = t2[21];
        c.inv_pclk     = t2[22];
        c.inv_de       = t2[23];
        c.sync_fall    = t2[25] & t2[24];
        c.tft          = ctrl[7];
        return c;
    endfunction

endpackage

// File: rtl/lcdt_cfg_regs.sv
// Register bank with a frame-synchronous shadow.
// Write-only staging words are decoded and copied into the live
// configuration whenever load_cfg is high (disabled, or at a frame wrap).
// The enable bit is taken live from the staged control word.
module lcdt_cfg_regs
    import lcdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              load_cfg,
    output logic              raster_en,
    output lcdt_cfg_t         cfg_q
);

    logic [REG_W-1:0] ctrl_q, t0_q, t1_q, t2_q;
    logic             unused_bits;

    // Capture register writes into the staging words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            t0_q   <= '0;
            t1_q   <= '0;
            t2_q   <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_CTRL: ctrl_q <= wr_data;
                ADDR_T0:   t0_q   <= wr_data;
                ADDR_T1:   t1_q   <= wr_data;
                default:   t2_q   <= wr_data;
            endcase
        end
    end

    // Reload the live configuration only at a safe point.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (load_cfg)
            cfg_q <= lcdt_decode(ctrl_q, t0_q, t1_q, t2_q);
    end

    assign raster_en   = ctrl_q[0];
    assign unused_bits = ^{ctrl_q[REG_W-1:8], ctrl_q[6:1], t0_q[2:0],
                           t2_q[31], t2_q[7:6], t2_q[3:2]};

endmodule

// File: rtl/lcdt_axis.sv
// One scan axis: a counter that runs over sync, back porch, active and
// front porch, in that order. The same module serves columns and lines.
// Assumes the phase lengths stay fixed while step is active mid-period.
module lcdt_axis #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         step,
    input  logic [W-1:0] sync_len,
    input  logic [W-1:0] back_len,
    input  logic [W-1:0] act_len,
    input  logic [W-1:0] front_len,
    output logic [W-1:0] cnt,
    output logic         last,
    output logic         in_sync,
    output logic         in_active,
    output logic [W-1:0] act_pos
);

    logic [W-1:0] total;
    logic [W-1:0] act_start;
    logic [W-1:0] act_end;

    // Phase boundaries derived from the programmed lengths.
    always_comb begin
        act_start = sync_len + back_len;
        act_end   = act_start + act_len;
        total     = act_end + front_len;
    end

    // Position counter, wrapping at the end of the period.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            cnt <= '0;
        else if (step)
            cnt <= last ? '0 : cnt + W'(1);
    end

    assign last      = (cnt == total - W'(1));
    assign in_sync   = (cnt < sync_len);
    assign in_active = (cnt >= act_start) && (cnt < act_end);
    assign act_pos   = cnt - act_start;

endmodule

// File: rtl/lcdt_acbias.sv
// Line-paced bias toggle and toggle-count pulse.
// Flips the bias level after every `period` line ends and pulses irq_out
// for one clock on every `irq_every`-th flip. A zero count disables either.
module lcdt_acbias #(
    parameter int N_W = 8,
    parameter int M_W = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear,
    input  logic           line_end,
    input  logic [N_W-1:0] period,
    input  logic [M_W-1:0] irq_every,
    output logic           ac_out,
    output logic           irq_out
);

    logic [N_W-1:0] line_cnt;
    logic [M_W-1:0] flip_cnt;

    // Count lines, flip the bias and count flips for the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            line_cnt <= '0;
            flip_cnt <= '0;
            ac_out   <= 1'b0;
            irq_out  <= 1'b0;
        end else begin
            irq_out <= 1'b0;
            if (line_end && (period != '0)) begin
                if (line_cnt == period - N_W'(1)) begin
                    line_cnt <= '0;
                    ac_out   <= ~ac_out;
                    if (irq_every != '0) begin
                        if (flip_cnt == irq_every - M_W'(1)) begin
                            flip_cnt <= '0;
                            irq_out  <= 1'b1;
                        end else begin
                            flip_cnt <= flip_cnt + M_W'(1);
                        end
                    end
                end else begin
                    line_cnt <= line_cnt + N_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/lcdt_raster.sv
// Top of the raster timing generator.
// Chains a column axis and a line axis, registers the decoded sync,
// enable and position, and applies polarity on the way out. Everything
// runs on the pixel clock; outputs lag the counters by one clock.
module lcdt_raster
    import lcdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic              lcd_hsync,
    output logic              lcd_vsync,
    output logic              lcd_de,
    output logic [HCNT_W-1:0] pixel_x,
    output logic [VCNT_W-1:0] pixel_y,
    output logic              ac_bias,
    output logic              ac_irq,
    output logic              pclk_invert,
    output logic              sync_fall_edge,
    output logic              tft_mode
);

    lcdt_cfg_t         cfg_q;
    logic              raster_en;
    logic              frame_wrap;
    logic [HCNT_W-1:0] h_cnt, h_pos;
    logic [VCNT_W-1:0] v_cnt, v_pos;
    logic              h_last, h_sync, h_act;
    logic              v_last, v_sync, v_act;
    logic              hs_q, vs_q, de_q;
    logic              pol_hs_q, pol_vs_q, pol_de_q;

    assign frame_wrap = raster_en & h_last & v_last;

    lcdt_cfg_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr_en),
        .wr_addr   (reg_addr),
        .wr_data   (reg_wdata),
        .load_cfg  (!raster_en || frame_wrap),
        .raster_en (raster_en),
        .cfg_q     (cfg_q)
    );

    lcdt_axis #(.W(HCNT_W)) u_haxis (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (!raster_en),
        .step      (raster_en),
        .sync_len  (cfg_q.h_sync),
        .back_len  (cfg_q.h_back),
        .act_len   (cfg_q.h_act),
        .front_len (cfg_q.h_front),
        .cnt       (h_cnt),
        .last      (h_last),
        .in_sync   (h_sync),
        .in_active (h_act),
        .act_pos   (h_pos)
    );

    lcdt_axis #(.W(VCNT_W)) u_vaxis (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (!raster_en),
        .step      (raster_en & h_last),
        .sync_len  (cfg_q.v_sync),
        .back_len  (cfg_q.v_back),
        .act_len   (cfg_q.v_act),
        .front_len (cfg_q.v_front),
        .cnt       (v_cnt),
        .last      (v_last),
        .in_sync   (v_sync),
        .in_active (v_act),
        .act_pos   (v_pos)
    );

    lcdt_acbias #(.N_W(ACN_W), .M_W(ACM_W)) u_acb (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (!raster_en),
        .line_end  (raster_en & h_last),
        .period    (cfg_q.ac_lines),
        .irq_every (cfg_q.ac_irq_every),
        .ac_out    (ac_bias),
        .irq_out   (ac_irq)
    );

    // Register the logical sync, enable and position for the current pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_q    <= 1'b0;
            vs_q    <= 1'b0;
            de_q    <= 1'b0;
            pixel_x <= '0;
            pixel_y <= '0;
        end else if (!raster_en) begin
            hs_q    <= 1'b0;
            vs_q    <= 1'b0;
            de_q    <= 1'b0;
            pixel_x <= '0;
            pixel_y <= '0;
        end else begin
            hs_q    <= h_sync;
            vs_q    <= v_sync;
            de_q    <= h_act & v_act;
            pixel_x <= (h_act & v_act) ? h_pos : '0;
            pixel_y <= (h_act & v_act) ? v_pos : '0;
        end
    end

    // Keep the polarity aligned with the pixel it applies to.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_hs_q <= 1'b0;
            pol_vs_q <= 1'b0;
            pol_de_q <= 1'b0;
        end else begin
            pol_hs_q <= cfg_q.inv_hs;
            pol_vs_q <= cfg_q.inv_vs;
            pol_de_q <= cfg_q.inv_de;
        end
    end

    assign lcd_hsync      = hs_q ^ pol_hs_q;
    assign lcd_vsync      = vs_q ^ pol_vs_q;
    assign lcd_de         = de_q ^ pol_de_q;
    assign pclk_invert    = cfg_q.inv_pclk;
    assign sync_fall_edge = cfg_q.sync_fall;
    assign tft_mode       = cfg_q.tft;

endmodule

// File: rtl/lcdt_raster_checker.sv
// Property checker for lcdt_raster, attached by bind below.
// Watches the counters, the shadow configuration and the registered outputs.
module lcdt_raster_checker
    import lcdt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              raster_en,
    input logic              frame_wrap,
    input logic [HCNT_W-1:0] h_cnt,
    input logic [VCNT_W-1:0] v_cnt,
    input lcdt_cfg_t         cfg_q,
    input logic              de_q,
    input logic              hs_q,
    input logic [HCNT_W-1:0] pixel_x,
    input logic              ac_irq
);

    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !raster_en |=> (h_cnt == '0 && v_cnt == '0)); // R8

    AST_SHADOW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (raster_en && !frame_wrap) |=> $stable(cfg_q)); // R9

    AST_DE_OUTSIDE_HSYNC: assert property (@(posedge clk) disable iff (!rst_n)
        de_q |-> !hs_q); // R4

    AST_X_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        de_q ##1 de_q |-> pixel_x == $past(pixel_x) + HCNT_W'(1)); // R5

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ac_irq |=> !ac_irq); // R11

endmodule

bind lcdt_raster lcdt_raster_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .raster_en  (raster_en),
    .frame_wrap (frame_wrap),
    .h_cnt      (h_cnt),
    .v_cnt      (v_cnt),
    .cfg_q      (cfg_q),
    .de_q       (de_q),
    .hs_q       (hs_q),
    .pixel_x    (pixel_x),
    .ac_irq     (ac_irq)
);

// File: tb/lcdt_raster_bench.sv
// Bench for lcdt_raster: a behavioural integer model stepped on each
// rising edge, compared with every output on each falling edge.
module lcdt_raster_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic        lcd_hsync, lcd_vsync, lcd_de, ac_bias, ac_irq;
    logic        pclk_invert, sync_fall_edge, tft_mode;
    logic [12:0] pixel_x;
    logic [11:0] pixel_y;

    int checks = 0;
    int errors = 0;
    bit started = 1'b0;
    bit done = 1'b0;
    string phase = "R1 reset";

    always #10 clk = ~clk;

    lcdt_raster u_lcdt_raster (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .lcd_hsync(lcd_hsync), .lcd_vsync(lcd_vsync),
        .lcd_de(lcd_de), .pixel_x(pixel_x), .pixel_y(pixel_y),
        .ac_bias(ac_bias), .ac_irq(ac_irq), .pclk_invert(pclk_invert),
        .sync_fall_edge(sync_fall_edge), .tft_mode(tft_mode)
    );

    // model state
    logic [31:0] m_ctrl = 0, m_t0 = 0, m_t1 = 0, m_t2 = 0;
    int c_hsw, c_hbp, c_hact, c_hfp, c_vsw, c_vbp, c_vact, c_vfp, c_n, c_m;
    bit c_ivs, c_ihs, c_ipc, c_ide, c_fall, c_tft;
    int h = 0, v = 0, lc = 0, tc = 0;
    bit ac = 0;
    bit e_hs = 0, e_vs = 0, e_de = 0, e_irq = 0;
    int e_x = 0, e_y = 0;

    task automatic load_cfg();
        c_hact = (int'({m_t0[3], m_t0[9:4]}) + 1) * 16;               // R2
        c_hsw  = int'({m_t2[30:27], m_t0[15:10]}) + 1;
        c_hfp  = int'({m_t2[1:0], m_t0[23:16]}) + 1;
        c_hbp  = int'({m_t2[5:4], m_t0[31:24]}) + 1;
        c_vact = int'({m_t2[26], m_t1[9:0]}) + 1;                     // R3
        c_vsw  = int'(m_t1[15:10]) + 1;
        c_vfp  = int'(m_t1[23:16]);
        c_vbp  = int'(m_t1[31:24]);
        c_n = int'(m_t2[15:8]);
        c_m = int'(m_t2[19:16]);
        c_ivs = m_t2[20]; c_ihs = m_t2[21]; c_ipc = m_t2[22]; c_ide = m_t2[23];
        c_fall = m_t2[25] && m_t2[24];
        c_tft = m_ctrl[7];
    endtask

    task automatic clear_cfg();
        c_hsw = 1; c_hbp = 1; c_hact = 16; c_hfp = 1;
        c_vsw = 1; c_vbp = 0; c_vact = 1; c_vfp = 0; c_n = 0; c_m = 0;
        c_ivs = 0; c_ihs = 0; c_ipc = 0; c_ide = 0; c_fall = 0; c_tft = 0;
    endtask

    initial clear_cfg();

    // reference model, one step per rising edge
    always @(posedge clk) begin
        started <= 1'b1;
        if (!rst_n) begin
            m_ctrl = 0; m_t0 = 0; m_t1 = 0; m_t2 = 0;
            clear_cfg();
            h = 0; v = 0; lc = 0; tc = 0; ac = 0;
            e_hs = 0; e_vs = 0; e_de = 0; e_irq = 0; e_x = 0; e_y = 0;
        end else begin
            if (m_ctrl[0]) begin
                bit ha, va;
                int hs0, vs0, ht, vt;
                hs0 = c_hsw + c_hbp;
                vs0 = c_vsw + c_vbp;
                ht = hs0 + c_hact + c_hfp;
                vt = vs0 + c_vact + c_vfp;
                ha = (h >= hs0) && (h < hs0 + c_hact);
                va = (v >= vs0) && (v < vs0 + c_vact);
                e_hs = (h < c_hsw) ^ c_ihs;
                e_vs = (v < c_vsw) ^ c_ivs;
                e_de = (ha && va) ^ c_ide;
                e_x = (ha && va) ? h - hs0 : 0;
                e_y = (ha && va) ? v - vs0 : 0;
                e_irq = 0;
                if (h == ht - 1 && c_n != 0) begin
                    if (lc == c_n - 1) begin
                        lc = 0;
                        ac = ~ac;
                        if (c_m != 0) begin
                            if (tc == c_m - 1) begin tc = 0; e_irq = 1; end
                            else tc++;
                        end
                    end else lc++;
                end
                if (h == ht - 1) begin
                    h = 0;
                    if (v == vt - 1) begin v = 0; load_cfg(); end
                    else v++;
                end else h++;
            end else begin
                e_hs = c_ihs; e_vs = c_ivs; e_de = c_ide;
                e_x = 0; e_y = 0; e_irq = 0;
                h = 0; v = 0; lc = 0; tc = 0; ac = 0;
                load_cfg();
            end
            if (reg_wr_en) begin
                case (reg_addr)
                    2'd0: m_ctrl = reg_wdata;
                    2'd1: m_t0 = reg_wdata;
                    2'd2: m_t1 = reg_wdata;
                    default: m_t2 = reg_wdata;
                endcase
            end
        end
    end

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s [%s] at %0t: actual %0d expected %0d", tag, phase, $time, act, exp);
        end
    endtask

    // compare every output away from the active edge
    always @(negedge clk) begin
        if (started && !done) begin
            check("R2 R4 R6 hsync", int'(lcd_hsync), int'(e_hs));
            check("R3 R4 R6 vsync", int'(lcd_vsync), int'(e_vs));
            check("R5 R6 de", int'(lcd_de), int'(e_de));
            check("R5 pixel_x", int'(pixel_x), e_x);
            check("R5 pixel_y", int'(pixel_y), e_y);
            check("R10 ac_bias", int'(ac_bias), int'(ac));
            check("R11 ac_irq", int'(ac_irq), int'(e_irq));
            check("R6 pclk_invert", int'(pclk_invert), int'(c_ipc));
            check("R7 sync_fall_edge", int'(sync_fall_edge), int'(c_fall));
            check("R8 tft_mode", int'(tft_mode), int'(c_tft));
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // configuration words
    localparam logic [31:0] A_T0 = (32'd2 << 24) | (32'd1 << 16) | (32'd1 << 10);
    localparam logic [31:0] A_T1 = (32'd1 << 24) | (32'd2 << 16) | 32'd2;
    localparam logic [31:0] A_T2 = (32'd2 << 16) | (32'd2 << 8);
    localparam logic [31:0] B_T0 = (32'd2 << 16) | (32'd1 << 4);
    localparam logic [31:0] B_T1 = (32'd1 << 10) | 32'd1;
    localparam logic [31:0] B_T2 = 32'h00F0_0000;
    localparam logic [31:0] D_T2 = (32'd1 << 25) | (32'd1 << 24) | (32'd1 << 16) | (32'd1 << 8);
    localparam logic [31:0] C_T0 = (32'd2 << 24) | (32'd0 << 16) | (32'd3 << 10) | (32'd1 << 3);
    localparam logic [31:0] C_T1 = (32'd1 << 24) | (32'd0 << 16);
    localparam logic [31:0] C_T2 = (32'd1 << 27) | (32'd1 << 4) | (32'd1 << 0) | (32'd1 << 26);

    initial begin
        run(3);
        rst_n = 1'b1;
        run(1);
        // R1: outputs idle after reset
        check("R1 reset hsync", int'(lcd_hsync), 0);
        check("R1 reset de", int'(lcd_de), 0);
        check("R1 reset pixel_x", int'(pixel_x), 0);
        check("R1 reset ac_bias", int'(ac_bias), 0);
        run(3);
        phase = "R2 R4 base frame";
        wr(2'd1, A_T0); wr(2'd2, A_T1); wr(2'd3, A_T2);
        wr(2'd0, 32'h81);
        run(340);
        phase = "R9 shadow";
        wr(2'd1, B_T0); wr(2'd2, B_T1); wr(2'd3, B_T2);
        run(400);
        phase = "R8 disable";
        wr(2'd0, 32'h0);
        run(5);
        phase = "R7 R8 flags while idle";
        wr(2'd3, D_T2); wr(2'd0, 32'h80);
        run(5);
        phase = "R10 R11 every line";
        wr(2'd0, 32'h81);
        run(400);
        phase = "R2 R3 high fields";
        wr(2'd0, 32'h0);
        wr(2'd1, C_T0); wr(2'd2, C_T1); wr(2'd3, C_T2);
        wr(2'd0, 32'h01);
        run(6600);
        phase = "R8 disable mid line";
        wr(2'd0, 32'h0);
        run(10);
        done = 1'b1;
        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
        end
    end

endmodule